// File: doc/BRIEF.md
# Supply-supervisor reset sequencer

This block turns a digital supply-low flag, produced by an external comparator, into a system reset. Both polarities are driven together. The flag is first brought into the clock domain. A consecutive-cycle counter then rejects short pulses on it. Once the flag is accepted, reset is raised within a few clock cycles. Reset stays high for as long as the flag is present. After the flag clears, reset is held for a long recovery window before it is released.

A watchdog input is also monitored. Any change of its level, rising or falling, counts as a sign of life. If no change arrives within a timeout, the block runs the same recovery window as for a supply dip.

Every time constant is given in nanoseconds and converted to clock cycles from the clock-period parameter. A bench can therefore shrink the constants. The rejection window is capped so that the reset deadline is always met.

The sequencer has three states:

- **RUN**: reset is released and the watchdog counts.
- **LOW**: the supply is low and reset is held.
- **HOLD**: the recovery window is counting and reset is held.

The transitions between them are:

- **T_LOW_ENTER**: any state goes to LOW while an accepted supply-low is present.
- **T_LOW_EXIT**: LOW goes to HOLD when the accepted flag drops. The hold count starts from zero.
- **T_HOLD_DONE**: HOLD goes to RUN when the hold count reaches its end.
- **T_WDOG_EXPIRE**: RUN goes to HOLD when the watchdog times out.

The internal reset `rst_n` clears the sequencer's own flops into HOLD. This makes power-up behave like a recovery window.

Top module: `supply_reset_seq`

## Requirements
- R1: A pulse on `supply_low` that lasts fewer than G clock cycles does not assert reset. G is the glitch length in cycles, which is 5 with a 20 ns clock and 100 ns glitch width.
- R2: When `supply_low` stays high for at least G cycles, `rst_out` rises at the (G+3)th rising edge after the input rises. That edge is inside the assert deadline, which defaults to 5 µs.
- R3: After an accepted supply-low drops, reset is released at the (w+H+4)th rising edge counted from its rise. Here w is the pulse length and H is the hold length in cycles.
- R4: `rst_out_n` is always the complement of `rst_out`.
- R5: Reset stays asserted on every cycle between the assert edge and the release edge, including the whole time the supply is low.
- R6: A change of level on `wdog_kick` in either direction restarts the watchdog. With no change for W cycles in RUN, reset asserts at the (W+3)th edge after the last change. It is then held for H cycles.
- R7: The watchdog is cleared while reset is asserted, and changes on `wdog_kick` during reset have no effect. After any release, the next watchdog reset without kicks comes exactly W cycles later.
- R8: An accepted supply-low during HOLD restarts the full hold from zero, counted from its drop. A rejected pulse during HOLD leaves the release edge unchanged.
- R9: After `rst_n` is released, reset is released at the Hth rising edge.
- R10: While `rst_n` is low, `rst_out` is 1 and `rst_out_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low clear of the sequencer flops |
| supply_low | input | 1 | Asynchronous supply-below-threshold flag |
| wdog_kick | input | 1 | Asynchronous activity signal; any level change is a kick |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset |

## Verification
The bench sweeps every supply-low pulse length from one cycle up to just past the glitch limit. A filter that is off by one would either let a G-1 cycle pulse through or miss a G cycle pulse. Exact assert and release edges are compared, so a missing synchronizer stage or a hold counter that is one cycle short shows up as a shifted edge. A second dip during HOLD must push the release out, while a rejected pulse there must not; a hold counter that fails to restart would release early. Watchdog timeouts are tried after a rising and after a falling final kick, with kicks sprinkled during the hold. A design that counts only one edge direction, or lets kicks or counts leak through reset, would reassert at the wrong cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [1:0] {
        SRS_RUN  = 2'd0,
        SRS_LOW  = 2'd1,
        SRS_HOLD = 2'd2
    } srs_state_e;

    function automatic int unsigned ns_to_cyc_up(input int unsigned ns, input int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned ns_to_cyc_dn(input int unsigned ns, input int unsigned per);
        return (ns / per < 2) ? 2 : ns / per;
    endfunction

    function automatic int unsigned clamp_glitch(input int unsigned want, input int unsigned deadline);
        int unsigned lim;
        lim = (deadline > 4) ? deadline - 3 : 1;
        if (want < 1) return 1;
        return (want > lim) ? lim : want;
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/srs_glitch_filter.sv
module srs_glitch_filter #(
    parameter int unsigned LEN = 5,
    parameter int unsigned CW  = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic valid
);

    logic [CW-1:0] run_len;

    assign valid = (run_len == CW'(LEN));

    // Counts consecutive high samples and saturates at LEN; any low sample clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_len <= '0;
        else if (!raw)  run_len <= '0;
        else if (!valid) run_len <= run_len + 1'b1;
    end

endmodule

// File: rtl/srs_wdog.sv
module srs_wdog #(
    parameter int unsigned TIMEOUT = 100,
    parameter int unsigned CW      = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick_lvl,
    input  logic          run,
    output logic          expire,
    output logic [CW-1:0] cnt_o
);

    logic          prev_lvl;
    logic          kick;
    logic [CW-1:0] cnt;

    assign kick   = kick_lvl ^ prev_lvl;
    assign expire = run && !kick && (cnt == CW'(TIMEOUT - 1));
    assign cnt_o  = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= kick_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt <= '0;
        else if (!run || kick || expire) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import srs_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned GLITCH_NS     = 100,
    parameter int unsigned ASSERT_MAX_NS = 5000,
    parameter int unsigned HOLD_NS       = 200_000_000,
    parameter int unsigned WDOG_NS       = 1_600_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic wdog_kick,
    output logic rst_out_n,
    output logic rst_out
);

    localparam int unsigned ASSERT_CYC = ASSERT_MAX_NS / CLK_PERIOD_NS;
    localparam int unsigned GLITCH_CYC =
        clamp_glitch(ns_to_cyc_up(GLITCH_NS, CLK_PERIOD_NS), ASSERT_CYC);
    localparam int unsigned HOLD_CYC   = ns_to_cyc_dn(HOLD_NS, CLK_PERIOD_NS);
    localparam int unsigned WDOG_CYC   = ns_to_cyc_dn(WDOG_NS, CLK_PERIOD_NS);
    localparam int unsigned HW         = $clog2(HOLD_CYC + 1);
    localparam int unsigned WW         = $clog2(WDOG_CYC + 1);

    logic [1:0]    sync_q;
    logic          low_s;
    logic          kick_s;
    logic          low_valid;
    logic          wd_expire;
    logic [WW-1:0] wd_cnt;
    logic [HW-1:0] hold_cnt;
    logic          hold_done;
    srs_state_e    state_q;
    srs_state_e    state_d;
    logic          rst_hi_q;
    logic          rst_lo_q;

    srs_sync #(
        .WIDTH  (2),
        .STAGES (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wdog_kick, supply_low}),
        .q     (sync_q)
    );

    assign low_s  = sync_q[0];
    assign kick_s = sync_q[1];

    srs_glitch_filter #(
        .LEN (GLITCH_CYC)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (low_s),
        .valid (low_valid)
    );

    srs_wdog #(
        .TIMEOUT (WDOG_CYC),
        .CW      (WW)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_lvl (kick_s),
        .run      (state_q == SRS_RUN),
        .expire   (wd_expire),
        .cnt_o    (wd_cnt)
    );

    // Hold counter: zero on entry to HOLD, counts every cycle spent there.
    assign hold_done = (hold_cnt == HW'(HOLD_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hold_cnt <= '0;
        else if (state_q != SRS_HOLD) hold_cnt <= '0;
        else                         hold_cnt <= hold_cnt + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (low_valid) begin
            state_d = SRS_LOW;                     // T_LOW_ENTER
        end else begin
            unique case (state_q)
                SRS_RUN:  if (wd_expire) state_d = SRS_HOLD;  // T_WDOG_EXPIRE
                SRS_LOW:  state_d = SRS_HOLD;                  // T_LOW_EXIT
                SRS_HOLD: if (hold_done) state_d = SRS_RUN;    // T_HOLD_DONE
                default:  state_d = SRS_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRS_HOLD;
        else        state_q <= state_d;
    end

    // Output register: both polarities follow the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_hi_q <= 1'b1;
            rst_lo_q <= 1'b0;
        end else begin
            rst_hi_q <= (state_d != SRS_RUN);
            rst_lo_q <= (state_d == SRS_RUN);
        end
    end

    assign rst_out   = rst_hi_q;
    assign rst_out_n = rst_lo_q;

endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
    parameter int unsigned HOLD_CYC   = 50,
    parameter int unsigned ASSERT_CYC = 250,
    parameter int unsigned WW         = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          supply_low,
    input logic          rst_out,
    input logic          rst_out_n,
    input logic          low_valid,
    input logic          wd_expire,
    input logic [WW-1:0] wd_cnt
);

    int unsigned lat_cnt;
    int unsigned held_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt  <= 0;
            held_cnt <= 0;
        end else begin
            if (supply_low && !rst_out) lat_cnt <= (lat_cnt < ASSERT_CYC + 2) ? lat_cnt + 1 : lat_cnt;
            else                        lat_cnt <= 0;
            if (low_valid)    held_cnt <= 0;
            else if (rst_out) held_cnt <= (held_cnt < HOLD_CYC + 4) ? held_cnt + 1 : held_cnt;
            else              held_cnt <= 0;
        end
    end

    a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == !rst_out_n);

    a_r2_assert_deadline: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt <= ASSERT_CYC);

    a_r5_low_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
        low_valid |=> rst_out);

    a_r1_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> ($past(low_valid) || $past(wd_expire)));

    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (held_cnt + 2 >= HOLD_CYC));

    a_r7_wdog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out && $past(rst_out)) |-> (wd_cnt == '0));

endmodule

bind supply_reset_seq srs_chk #(
    .HOLD_CYC   (HOLD_CYC),
    .ASSERT_CYC (ASSERT_CYC),
    .WW         (WW)
) u_srs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_low (supply_low),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .low_valid  (low_valid),
    .wd_expire  (wd_expire),
    .wd_cnt     (wd_cnt)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;

    localparam int PER = 20;
    localparam int GNS = 100;
    localparam int HNS = 1000;
    localparam int WNS = 2000;
    localparam int G   = (GNS + PER - 1) / PER;
    localparam int H   = HNS / PER;
    localparam int W   = WNS / PER;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic wdog_kick = 1'b0;
    logic rst_out_n;
    logic rst_out;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(PER / 2) clk = ~clk;

    supply_reset_seq #(
        .CLK_PERIOD_NS (PER),
        .GLITCH_NS     (GNS),
        .ASSERT_MAX_NS (5000),
        .HOLD_NS       (HNS),
        .WDOG_NS       (WNS)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .wdog_kick  (wdog_kick),
        .rst_out_n  (rst_out_n),
        .rst_out    (rst_out)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Supply-low schedule: high on edges 1..w1 and s2+1..s2+w2.
    task automatic run_sched(input int w1, input int s2, input int w2,
                             input int exp_as, input int exp_rel, input int limit,
                             input string rel_tag);
        int first_as = 0;
        int first_rel = 0;
        int n_as = 0;
        int mism = 0;
        for (int t = 1; t <= limit; t++) begin
            supply_low = (t <= w1) || (t > s2 && t <= s2 + w2);
            if (t == 1) wdog_kick = ~wdog_kick;
            step();
            if (rst_out !== ~rst_out_n) mism++;
            if (rst_out) n_as++;
            if (rst_out && first_as == 0) first_as = t;
            if (!rst_out && first_as != 0 && first_rel == 0) first_rel = t;
        end
        supply_low = 1'b0;
        if (exp_as == 0) begin
            check_eq("R1 short pulse ignored, asserted cycles", n_as, 0);
        end else begin
            check_eq("R2 assert edge", first_as, exp_as);
            check_eq(rel_tag, first_rel, exp_rel);
            check_eq("R5 contiguous asserted cycles", n_as, exp_rel - exp_as);
        end
        check_eq("R4 complement mismatches", mism, 0);
    endtask

    task automatic run_wd();
        int first_as = 0;
        int first_rel = 0;
        int re_as = 0;
        int mism = 0;
        for (int t = 1; t <= 2 * W + H + 5; t++) begin
            supply_low = 1'b0;
            if (t == 1 || t == W + 13 || t == W + 23) wdog_kick = ~wdog_kick;
            step();
            if (rst_out !== ~rst_out_n) mism++;
            if (rst_out && first_as == 0) first_as = t;
            else if (!rst_out && first_as != 0 && first_rel == 0) first_rel = t;
            else if (rst_out && first_rel != 0 && re_as == 0) re_as = t;
        end
        check_eq("R6 watchdog expiry edge", first_as, W + 3);
        check_eq("R6 hold after expiry", first_rel, W + 3 + H);
        check_eq("R7 full window after release", re_as, W + 3 + H + W);
        check_eq("R4 complement mismatches", mism, 0);
    endtask

    task automatic wait_release();
        for (int t = 0; t < 4 * H; t++) begin
            step();
            if (!rst_out) break;
        end
    endtask

    initial begin : main
        int t_rel;
        int n_as;
        // R10: outputs asserted while the internal clear is held
        for (int i = 0; i < 3; i++) begin
            step();
            check_eq("R10 rst_out in clear", int'(rst_out), 1);
            check_eq("R10 rst_out_n in clear", int'(rst_out_n), 0);
        end
        rst_n = 1'b1;
        // R9: power-up hold
        t_rel = 0;
        for (int t = 1; t <= 2 * H; t++) begin
            step();
            if (!rst_out) begin
                t_rel = t;
                break;
            end
        end
        check_eq("R9 power-up release edge", t_rel, H);

        // R6: regular kicks of both directions keep reset released
        n_as = 0;
        for (int t = 1; t <= 260; t++) begin
            if (t % 40 == 1) wdog_kick = ~wdog_kick;
            step();
            if (rst_out) n_as++;
        end
        check_eq("R6 kicked watchdog asserted cycles", n_as, 0);

        // R1 R2 R3 R5: sweep of pulse lengths around the glitch limit
        for (int w = 1; w <= G + 3; w++) begin
            if (w < G) run_sched(w, 0, 0, 0, 0, 25, "R1");
            else       run_sched(w, 0, 0, G + 3, w + H + 4, w + H + 6, "R3 release edge");
        end
        run_sched(G + 25, 0, 0, G + 3, G + 25 + H + 4, G + 25 + H + 6, "R3 release edge long dip");

        // R8: second dip during HOLD restarts the hold; a glitch does not
        run_sched(G + 1, 30, G + 2, G + 3, 30 + G + 2 + H + 4, 30 + G + 2 + H + 6,
                  "R8 restarted release edge");
        run_sched(G + 1, 30, G - 1, G + 3, G + 1 + H + 4, G + 1 + H + 6,
                  "R8 glitch in hold release edge");

        // R6 R7: timeout after a rising, then a falling final kick
        run_wd();
        wait_release();
        run_wd();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule